// File: doc/BRIEF.md
# Peripheral Interrupt Flag and Vector Unit

This block collects the interrupt status of three peripherals of a small 8-bit controller: a timer with two capture channels, two compare channels and an overflow, an asynchronous serial port, and a CAN controller. Single-cycle event pulses from each peripheral set sticky flags. Enable bits, some of which cover a group of flags, qualify those flags. The block turns the qualified flags into one interrupt request and a vector address for the CPU.

A narrow register bus lets the CPU read the status registers and read or write the control registers. Timer and CAN flags are cleared by writing ones to their status register. Serial flags clear only through a two-step handshake: a status read taken while a flag is set, followed by any access to the serial data address. The CAN wake-up flag has no enable and ignores the global mask. Every other source is blocked by the global mask input.

Top module: `periph_irq_vec`

## Requirements
- R1: After reset, every flag and enable reads as zero at every address, `irq` is 0 and `irq_vec` is 0.
- R2: Timer event bits `tmr_evt[4:0]` are, from bit 4 down: capture 1, capture 2, compare 1, compare 2, overflow. They set flags that read back at address 0, bits 7 to 3, in the same order. Writing 1 to one of those bits at address 0 clears that flag.
- R3: Address 1 holds the timer enables, which read back with bits 4 to 0 as zero. Bit 7 enables both capture flags, bit 6 enables both compare flags, and bit 5 enables overflow.
- R4: Serial event bits `sci_evt[4:0]` are, from bit 4 down: transmit-empty, transmit-done, overrun, receive-full, idle. They set flags that read at address 2, bits 7 to 3. Address 3 holds the serial enables. Bit 7 enables transmit-empty, bit 6 enables transmit-done, bit 5 enables both overrun and receive-full, and bit 4 enables idle.
- R5: A read of address 2 arms exactly the serial flags set at that moment. The next read or write of address 4 clears the armed flags and disarms. Access to address 4 without a prior status read clears nothing, and a flag set after the status read survives the data access.
- R6: The CAN error and overrun events set address 5 bits 7 and 6, which are enabled by address 6 bits 7 and 6. `can_wake_evt` sets address 5 bit 5 only while `can_sleep` is 1. Writing 1 to those bits at address 5 clears them.
- R7: A pending wake-up flag drives `irq` to 1 with CAN vector, regardless of enables and `irq_mask`.
- R8: While `irq_mask` is 1 and no wake-up is pending, `irq` is 0 and `irq_vec` is 0.
- R9: `irq` is the OR of all enabled pending groups. `irq_vec` is taken from the highest of CAN, timer capture, timer compare, timer overflow, serial (`VEC_CAN`, `VEC_IC`, `VEC_OC`, `VEC_TOF`, `VEC_SCI`), and is 0 while `irq` is 0.
- R10: A set event that coincides with that flag's clear leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_mask | input | 1 | Global mask for all maskable sources |
| tmr_evt | input | 5 | Timer event pulses |
| sci_evt | input | 5 | Serial event pulses |
| can_err_evt | input | 1 | CAN error or bus state change pulse |
| can_ovr_evt | input | 1 | CAN receive overrun pulse |
| can_wake_evt | input | 1 | CAN bus activity pulse |
| can_sleep | input | 1 | CAN controller is in sleep mode |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 write, 0 read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, 0 when not reading |
| irq | output | 1 | Interrupt request |
| irq_vec | output | VEC_W | Vector address of the granted source |

## Verification
The bench builds the block with its default 16-bit vector width and default vector addresses. These defaults make all five group vectors distinct, so every grant decision is visible at the port. The flag and enable fields are small, so the bench can sweep all 256 timer flag and enable combinations and all 512 serial combinations. It can also sweep all 32 mixes of pending groups for priority. Directed cases then cover the handshake ordering, the sleep gate on wake-up, the mask, and set-versus-clear collisions.

// File: rtl/periph_irq_vec.sv
module periph_irq_vec #(
  parameter int VEC_W = 16,
  parameter logic [VEC_W-1:0] VEC_CAN = 16'h3FF0,
  parameter logic [VEC_W-1:0] VEC_SCI = 16'h3FF2,
  parameter logic [VEC_W-1:0] VEC_TOF = 16'h3FF4,
  parameter logic [VEC_W-1:0] VEC_OC  = 16'h3FF6,
  parameter logic [VEC_W-1:0] VEC_IC  = 16'h3FF8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             irq_mask,
  input  logic [4:0]       tmr_evt,
  input  logic [4:0]       sci_evt,
  input  logic             can_err_evt,
  input  logic             can_ovr_evt,
  input  logic             can_wake_evt,
  input  logic             can_sleep,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [2:0]       bus_addr,
  input  logic [7:0]       bus_wdata,
  output logic [7:0]       bus_rdata,
  output logic             irq,
  output logic [VEC_W-1:0] irq_vec
);
  localparam logic [2:0] A_TST = 3'd0, A_TCT = 3'd1, A_SST = 3'd2, A_SCT = 3'd3,
                         A_SDT = 3'd4, A_CST = 3'd5, A_CCT = 3'd6;

  logic [4:0] tmr_f, sci_f, sci_arm;
  logic [2:0] tmr_en, can_f;
  logic [3:0] sci_en;
  logic [1:0] can_en;

  wire rd = bus_sel & ~bus_wr;
  wire wr = bus_sel & bus_wr;
  wire sci_data_acc = bus_sel & (bus_addr == A_SDT);
  wire unused_wdata = ^bus_wdata[2:0];

  wire [4:0] tmr_clr = (wr && bus_addr == A_TST) ? bus_wdata[7:3] : 5'd0;
  wire [2:0] can_clr = (wr && bus_addr == A_CST) ? bus_wdata[7:5] : 3'd0;
  wire [4:0] sci_clr = sci_data_acc ? sci_arm : 5'd0;
  wire [2:0] can_set = {can_err_evt, can_ovr_evt, can_wake_evt & can_sleep};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_f <= '0; sci_f <= '0; sci_arm <= '0; can_f <= '0;
      tmr_en <= '0; sci_en <= '0; can_en <= '0;
    end else begin
      tmr_f <= tmr_evt | (tmr_f & ~tmr_clr);
      sci_f <= sci_evt | (sci_f & ~sci_clr);
      can_f <= can_set | (can_f & ~can_clr);
      if (rd && bus_addr == A_SST) sci_arm <= sci_f;
      else if (sci_data_acc)       sci_arm <= '0;
      if (wr && bus_addr == A_TCT) tmr_en <= bus_wdata[7:5];
      if (wr && bus_addr == A_SCT) sci_en <= bus_wdata[7:4];
      if (wr && bus_addr == A_CCT) can_en <= bus_wdata[7:6];
    end
  end

  always_comb begin
    bus_rdata = 8'h00;
    if (rd)
      case (bus_addr)
        A_TST:   bus_rdata = {tmr_f, 3'b000};
        A_TCT:   bus_rdata = {tmr_en, 5'b00000};
        A_SST:   bus_rdata = {sci_f, 3'b000};
        A_SCT:   bus_rdata = {sci_en, 4'b0000};
        A_CST:   bus_rdata = {can_f, 5'b00000};
        A_CCT:   bus_rdata = {can_en, 6'b000000};
        default: bus_rdata = 8'h00;
      endcase
  end

  wire open_gate = ~irq_mask;
  wire g_can = can_f[0] | (open_gate & |(can_f[2:1] & can_en));
  wire g_ic  = open_gate & tmr_en[2] & |tmr_f[4:3];
  wire g_oc  = open_gate & tmr_en[1] & |tmr_f[2:1];
  wire g_tof = open_gate & tmr_en[0] & tmr_f[0];
  wire g_sci = open_gate & |(sci_f & {sci_en[3], sci_en[2], sci_en[1], sci_en[1], sci_en[0]});

  assign irq = g_can | g_ic | g_oc | g_tof | g_sci;
  assign irq_vec = g_can ? VEC_CAN : g_ic ? VEC_IC : g_oc ? VEC_OC :
                   g_tof ? VEC_TOF : g_sci ? VEC_SCI : '0;

  a_r2_timer_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_evt != 5'd0) |=> ((tmr_f & $past(tmr_evt)) == $past(tmr_evt)));
  a_r5_serial_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !sci_data_acc |=> (($past(sci_f) & ~sci_f) == 5'd0));
  a_r7_wake_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
    (can_wake_evt && can_sleep) |=> (irq && irq_vec == VEC_CAN));
  a_r8_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_mask && !can_f[0]) |-> !irq);
  a_r9_idle_vec_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !irq |-> (irq_vec == '0));
endmodule

// File: tb/periph_irq_vec_bench.sv
module periph_irq_vec_bench;
  logic clk = 1'b0, rst_n = 1'b0, irq_mask = 1'b0;
  logic [4:0] tmr_evt = '0, sci_evt = '0;
  logic can_err_evt = 0, can_ovr_evt = 0, can_wake_evt = 0, can_sleep = 0;
  logic bus_sel = 0, bus_wr = 0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic irq;
  logic [15:0] irq_vec;
  int checks = 0, fails = 0;
  logic [7:0] rv;

  always #4 clk = ~clk;

  periph_irq_vec u_periph_irq_vec (.*);

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s actual=%h expected=%h", tag, act, exp); end
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = a;
    #2 d = bus_rdata;
    @(negedge clk); bus_sel = 0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_wr = 0;
  endtask

  task automatic pulse(input logic [4:0] t, input logic [4:0] s, input logic [2:0] c);
    @(negedge clk); tmr_evt = t; sci_evt = s; {can_err_evt, can_ovr_evt, can_wake_evt} = c;
    @(negedge clk); tmr_evt = 0; sci_evt = 0; {can_err_evt, can_ovr_evt, can_wake_evt} = 0;
  endtask

  task automatic sample_irq(input bit ei, input logic [15:0] ev, input string tag);
    #2;
    chk(irq === ei, tag, {15'd0, irq}, {15'd0, ei});
    chk(irq_vec === ev, tag, irq_vec, ev);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++; $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      rd(a[2:0], rv); chk(rv == 8'h00, "R1 reset read", {8'd0, rv}, 16'd0);
    end
    sample_irq(1'b0, 16'h0000, "R1 reset irq");

    // R2 R3 R9 exhaustive timer sweep
    for (int p = 0; p < 32; p++)
      for (int e = 0; e < 8; e++) begin
        bit ic, oc, ov; logic [15:0] ev;
        pulse(p[4:0], 5'd0, 3'd0);
        wr(3'd1, {e[2:0], 5'b0});
        ic = e[2] && p[4:3] != 0; oc = e[1] && p[2:1] != 0; ov = e[0] && p[0];
        ev = ic ? 16'h3FF8 : oc ? 16'h3FF6 : ov ? 16'h3FF4 : 16'h0000;
        sample_irq(ic | oc | ov, ev, "R3 R9 timer enable/vector");
        rd(3'd0, rv); chk(rv == {p[4:0], 3'b0}, "R2 timer status", {8'd0, rv}, {8'd0, p[4:0], 3'b0});
        rd(3'd1, rv); chk(rv == {e[2:0], 5'b0}, "R3 timer control", {8'd0, rv}, {8'd0, e[2:0], 5'b0});
        wr(3'd0, 8'hF8); wr(3'd1, 8'h00);
        rd(3'd0, rv); chk(rv == 8'h00, "R2 timer clear", {8'd0, rv}, 16'd0);
      end

    // R4 R5 R9 exhaustive serial sweep
    for (int p = 0; p < 32; p++)
      for (int e = 0; e < 16; e++) begin
        bit x;
        pulse(5'd0, p[4:0], 3'd0);
        wr(3'd3, {e[3:0], 4'b0});
        x = (e[3] && p[4]) || (e[2] && p[3]) || (e[1] && p[2:1] != 0) || (e[0] && p[0]);
        sample_irq(x, x ? 16'h3FF2 : 16'h0000, "R4 R9 serial enable/vector");
        rd(3'd2, rv); chk(rv == {p[4:0], 3'b0}, "R4 serial status", {8'd0, rv}, {8'd0, p[4:0], 3'b0});
        rd(3'd4, rv);
        rd(3'd2, rv); chk(rv == 8'h00, "R5 serial cleared", {8'd0, rv}, 16'd0);
        wr(3'd3, 8'h00);
      end

    // R5 data access without status read clears nothing
    pulse(5'd0, 5'b11000, 3'd0);
    rd(3'd4, rv); wr(3'd4, 8'h55);
    rd(3'd2, rv); chk(rv == 8'hC0, "R5 no arm no clear", {8'd0, rv}, 16'h00C0);
    wr(3'd4, 8'h00);
    rd(3'd2, rv); chk(rv == 8'h00, "R5 write data clears", {8'd0, rv}, 16'd0);
    // R5 flag set after status read survives
    pulse(5'd0, 5'b10000, 3'd0);
    rd(3'd2, rv);
    pulse(5'd0, 5'b01000, 3'd0);
    rd(3'd4, rv);
    rd(3'd2, rv); chk(rv == 8'h40, "R5 late flag kept", {8'd0, rv}, 16'h0040);
    rd(3'd4, rv);
    rd(3'd2, rv); chk(rv == 8'h00, "R5 late flag cleared", {8'd0, rv}, 16'd0);

    // R6 R7 CAN
    pulse(5'd0, 5'd0, 3'b001);
    rd(3'd5, rv); chk(rv == 8'h00, "R6 wake ignored awake", {8'd0, rv}, 16'd0);
    pulse(5'd0, 5'd0, 3'b110);
    rd(3'd5, rv); chk(rv == 8'hC0, "R6 err/ovr flags", {8'd0, rv}, 16'h00C0);
    sample_irq(1'b0, 16'h0000, "R6 CAN disabled");
    wr(3'd6, 8'h40);
    sample_irq(1'b1, 16'h3FF0, "R6 CAN ovr enabled");
    rd(3'd6, rv); chk(rv == 8'h40, "R6 CAN control", {8'd0, rv}, 16'h0040);
    irq_mask = 1;
    sample_irq(1'b0, 16'h0000, "R8 mask blocks CAN");
    wr(3'd5, 8'hC0); wr(3'd6, 8'h00);
    can_sleep = 1;
    pulse(5'd0, 5'd0, 3'b001);
    sample_irq(1'b1, 16'h3FF0, "R7 wake under mask");
    rd(3'd5, rv); chk(rv == 8'h20, "R6 wake flag", {8'd0, rv}, 16'h0020);
    wr(3'd5, 8'h20); can_sleep = 0;
    sample_irq(1'b0, 16'h0000, "R6 wake cleared");
    irq_mask = 0;

    // R9 priority sweep over pending groups {can, ic, oc, tof, sci}
    wr(3'd1, 8'hE0); wr(3'd3, 8'hF0); wr(3'd6, 8'hC0);
    for (int g = 0; g < 32; g++) begin
      logic [15:0] ev;
      pulse({g[3], 1'b0, g[2], 1'b0, g[1]}, {g[0], 4'b0}, {g[4], 2'b00});
      ev = g[4] ? 16'h3FF0 : g[3] ? 16'h3FF8 : g[2] ? 16'h3FF6 : g[1] ? 16'h3FF4 :
           g[0] ? 16'h3FF2 : 16'h0000;
      sample_irq(g != 0, ev, "R9 priority");
      irq_mask = 1;
      sample_irq(1'b0, 16'h0000, "R8 mask all groups");
      irq_mask = 0;
      wr(3'd0, 8'hF8); wr(3'd5, 8'hE0); rd(3'd2, rv); rd(3'd4, rv);
    end
    wr(3'd1, 8'h00); wr(3'd3, 8'h00); wr(3'd6, 8'h00);

    // R10 set wins over clear
    pulse(5'b00001, 5'd0, 3'd0);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = 3'd0; bus_wdata = 8'hF8; tmr_evt = 5'b00001;
    @(negedge clk); bus_sel = 0; bus_wr = 0; tmr_evt = 0;
    rd(3'd0, rv); chk(rv == 8'h08, "R10 timer set wins", {8'd0, rv}, 16'h0008);
    pulse(5'd0, 5'b10000, 3'd0);
    rd(3'd2, rv);
    @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = 3'd4; sci_evt = 5'b10000;
    @(negedge clk); bus_sel = 0; sci_evt = 0;
    rd(3'd2, rv); chk(rv == 8'h80, "R10 serial set wins", {8'd0, rv}, 16'h0080);
    pulse(5'd0, 5'd0, 3'b100);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = 3'd5; bus_wdata = 8'h80; can_err_evt = 1;
    @(negedge clk); bus_sel = 0; bus_wr = 0; can_err_evt = 0;
    rd(3'd5, rv); chk(rv == 8'h80, "R10 CAN set wins", {8'd0, rv}, 16'h0080);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule